// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the head of a receive path and decides whether a frame should be kept. The frame's bytes flow in on a byte-wide valid/ready stream. The block looks only at the first six bytes, which hold the destination address. It tracks an exact match against the programmed station address and an all-ones (broadcast) test. In parallel it runs a CRC-32 over those six bytes to find a bit in a 64-entry multicast hash table. One cycle after the sixth address byte is taken, it raises a one-cycle decision strobe together with an accept flag. The remaining payload bytes pass through its input without effect, until the byte marked last closes the frame.

The stream never applies back-pressure. `in_ready` is high whenever reset is released, so a byte is taken on every rising edge where `in_valid` is high. Cycles with `in_valid` low are idle gaps and may occur anywhere in a frame. The configuration pins, the station address and the hash table are plain level inputs. They are sampled in the cycle that the sixth address byte is taken.

Top module: `rxf_filter`

## Requirements
- R1: `in_ready` is 1 whenever reset is deasserted. `dec_valid` pulses high for exactly one cycle: the cycle after the edge that takes the sixth byte of a frame. It pulses once per frame.
- R2: A cycle with `in_valid` low takes no byte and changes no state. Idle gaps inside the address bytes do not alter the decision or move the strobe.
- R3: With `cfg_promisc` = 1 every frame is accepted.
- R4: A destination of six 0xFF bytes is accepted exactly when `cfg_bcast` = 1 (promiscuous off).
- R5: A destination that is not all-ones, with bit 0 of its first byte set, is multicast. It is rejected whenever `cfg_mcast` = 0 (promiscuous off).
- R6: With `cfg_mcast` = 1, a multicast frame is accepted exactly when `hash_table[idx]` is 1. Here idx is bits 31:26 of a CRC register that starts at 0xFFFFFFFF and absorbs the six bytes in arrival order, each least significant bit first, with reflected polynomial 0xEDB88320 and no final inversion. Bit idx of `hash_table` is bit idx%8 of hash byte idx/8.
- R7: Any other destination is accepted exactly when arrival byte k equals `station_addr[8k+7:8k]` for all k = 0..5.
- R8: A frame whose `in_last` byte comes before its sixth byte produces no strobe. The next byte starts a new frame at address byte 0.
- R9: After reset, `dec_valid` and `dec_accept` are 0.
- R10: The configuration and table inputs matter only in the cycle the sixth byte is taken. A change on that same edge is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte can be taken (always 1 out of reset) |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_bcast | input | 1 | Accept broadcast frames |
| cfg_mcast | input | 1 | Accept multicast frames that hit the hash table |
| station_addr | input | 48 | Own address; first arrival byte in bits 7:0 |
| hash_table | input | 64 | Multicast hash bits, indexed by CRC bits 31:26 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Decision result, valid with dec_valid |

## Verification
The hardest case to reach from the ports is a multicast frame whose CRC-derived index lands on a set table bit, as opposed to one that lands on a clear bit. Random addresses alone rarely line up with a sparse table. The stimulus therefore forces the group bit on random addresses and pairs them with a random half-full table. That yields a mix of hits and misses, each predicted by a bench CRC written bit-serially. Short frames are sent just before full ones, so the restart of the byte position is tested. A promiscuous flip is timed onto the sixth byte itself.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // One byte of the reflected CRC-32, lsb first, no final inversion.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [31:0] crc_nxt
);
  logic [31:0] crc_q;

  assign crc_nxt = crc_byte(first ? CRC_SEED : crc_q, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= CRC_SEED;
    else if (en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track #(
  parameter int N_BYTES = 6,
  localparam int CW = $clog2(N_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               last,
  input  logic [7:0]         data,
  input  logic [8*N_BYTES-1:0] station,
  output logic               addr_beat,
  output logic               first_beat,
  output logic               final_beat,
  output logic               ones_nxt,
  output logic               match_nxt,
  output logic               grp_nxt
);
  logic [CW-1:0] pos_q;
  logic          ones_q, match_q, grp_q;
  logic [7:0]    sta_b [N_BYTES];
  logic [7:0]    sta_sel;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_sta
    assign sta_b[k] = station[8*k +: 8];
  end

  always_comb begin
    sta_sel = 8'h00;
    for (int k = 0; k < N_BYTES; k++)
      if (pos_q == CW'(k)) sta_sel = sta_b[k];
  end

  logic in_addr, at_first;
  assign in_addr    = pos_q < CW'(N_BYTES);
  assign at_first   = pos_q == '0;
  assign addr_beat  = beat && in_addr;
  assign first_beat = at_first;
  assign final_beat = beat && (pos_q == CW'(N_BYTES - 1));
  assign ones_nxt   = (at_first || ones_q) && (data == 8'hFF);
  assign match_nxt  = (at_first || match_q) && (data == sta_sel);
  assign grp_nxt    = at_first ? data[0] : grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      ones_q  <= 1'b0;
      match_q <= 1'b0;
      grp_q   <= 1'b0;
    end else if (beat) begin
      if (last)         pos_q <= '0;
      else if (in_addr) pos_q <= pos_q + 1'b1;
      if (in_addr) begin
        ones_q  <= ones_nxt;
        match_q <= match_nxt;
        grp_q   <= grp_nxt;
      end
    end
  end

  p_pos_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= CW'(N_BYTES));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> (pos_q == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(pos_q));
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter #(
  parameter int N_BYTES   = 6,
  parameter int HASH_BITS = 6,
  localparam int HASH_W   = 1 << HASH_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  input  logic                 cfg_promisc,
  input  logic                 cfg_bcast,
  input  logic                 cfg_mcast,
  input  logic [8*N_BYTES-1:0] station_addr,
  input  logic [HASH_W-1:0]    hash_table,
  output logic                 dec_valid,
  output logic                 dec_accept
);
  logic beat, addr_beat, first_beat, final_beat;
  logic ones_nxt, match_nxt, grp_nxt;
  logic [31:0] crc_nxt;
  logic [HASH_BITS-1:0] hidx;
  logic accept_c;

  assign in_ready = rst_n;
  assign beat     = in_valid && in_ready;

  rxf_addr_track #(.N_BYTES(N_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .data(in_data),
    .station(station_addr), .addr_beat(addr_beat), .first_beat(first_beat),
    .final_beat(final_beat), .ones_nxt(ones_nxt), .match_nxt(match_nxt),
    .grp_nxt(grp_nxt)
  );

  rxf_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .en(addr_beat), .first(first_beat),
    .data(in_data), .crc_nxt(crc_nxt)
  );

  assign hidx = crc_nxt[31 -: HASH_BITS];

  always_comb begin
    if (cfg_promisc)   accept_c = 1'b1;
    else if (ones_nxt) accept_c = cfg_bcast;
    else if (grp_nxt)  accept_c = cfg_mcast && hash_table[hidx];
    else               accept_c = match_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= final_beat;
      dec_accept <= final_beat && accept_c;
    end
  end

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && cfg_promisc) |=> (dec_valid && dec_accept));
  p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && !cfg_promisc && ones_nxt && !cfg_bcast) |=> !dec_accept);
  p_mcast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && !cfg_promisc && !ones_nxt && grp_nxt && !cfg_mcast) |=> !dec_accept);
  p_accept_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
endmodule

// File: tb/rxf_filter_tb_top.sv
module rxf_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic cfg_promisc = 1'b0, cfg_bcast = 1'b0, cfg_mcast = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] hash_table = 64'h0;
  logic dec_valid, dec_accept;
  int n_chk = 0, n_err = 0;
  bit flip_at_sixth = 0;

  always #5 clk = ~clk;

  rxf_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .cfg_promisc(cfg_promisc),
    .cfg_bcast(cfg_bcast), .cfg_mcast(cfg_mcast), .station_addr(station_addr),
    .hash_table(hash_table), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bit-serial model of the hash CRC.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ a[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    if (cfg_promisc) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return cfg_bcast;
    if (a[0]) return cfg_mcast && hash_table[ref_idx(a)];
    return a == station_addr;
  endfunction

  // Sends one frame; addr byte k in a[8k+7:8k]; checks strobe each cycle.
  task automatic send_frame(input logic [47:0] a, input int len, input bit gaps, input string req);
    bit exp_acc;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dec_valid == 1'b0, "R2 idle", dec_valid, 0);
      end
      in_valid = 1'b1;
      in_data  = (i < 6) ? a[8*i +: 8] : 8'($urandom);
      in_last  = (i == len - 1);
      if (i == 5 && flip_at_sixth) cfg_promisc = 1'b1;
      if (i == 5) exp_acc = ref_accept(a);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (i == 5) begin
        check(dec_valid == 1'b1, {"R1 strobe ", req}, dec_valid, 1);
        check(dec_accept == exp_acc, {req, " accept"}, dec_accept, exp_acc);
      end else begin
        check(dec_valid == 1'b0, "R1/R8 no strobe", dec_valid, 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0 && dec_accept == 1'b0, "R9 reset outputs", {dec_valid, dec_accept}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    station_addr = 48'h5634_1200_AB02;
    hash_table   = 64'h0;
    // R7 exact match and near miss
    send_frame(station_addr, 12, 0, "R7 match");
    send_frame(station_addr ^ 48'h0100_0000_0000, 10, 1, "R7 miss");
    // R4 broadcast both ways
    cfg_bcast = 1'b0; send_frame(48'hFFFF_FFFF_FFFF, 8, 0, "R4 bcast off");
    cfg_bcast = 1'b1; send_frame(48'hFFFF_FFFF_FFFF, 6, 1, "R4 bcast on");
    // R5 multicast disabled, full table
    hash_table = '1; cfg_mcast = 1'b0;
    send_frame(48'h0000_5E00_0001, 9, 0, "R5 mcast off");
    // R6 hit and miss on a single table bit
    cfg_mcast = 1'b1;
    a = 48'h0100_5E00_0001;
    hash_table = 64'h1 << ref_idx(a);
    send_frame(a, 7, 0, "R6 hit");
    hash_table = ~(64'h1 << ref_idx(a));
    send_frame(a, 7, 1, "R6 miss");
    // R3 promiscuous on a foreign unicast
    cfg_promisc = 1'b1; send_frame(48'h0000_0000_0002, 8, 0, "R3 promisc");
    cfg_promisc = 1'b0;
    // R8 short frame then full frame
    send_frame(48'h0, 4, 0, "R8 short");
    send_frame(station_addr, 8, 0, "R8 after short");
    // R10 promiscuous raised on the sixth byte edge
    flip_at_sixth = 1; send_frame(48'h0000_0000_0004, 8, 0, "R10 flip");
    flip_at_sixth = 0; cfg_promisc = 1'b0;

    for (int n = 0; n < 400; n++) begin
      int kind;
      int len;
      kind = $urandom_range(0, 4);
      a = {16'($urandom), 32'($urandom)};
      case (kind)
        0: a = 48'hFFFF_FFFF_FFFF;
        1: a[0] = 1'b1;
        2: a = station_addr;
        default: a[0] = 1'b0;
      endcase
      hash_table   = {32'($urandom), 32'($urandom)};
      cfg_promisc  = ($urandom_range(0, 7) == 0);
      cfg_bcast    = 1'($urandom);
      cfg_mcast    = ($urandom_range(0, 3) != 0);
      len = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 5) : $urandom_range(6, 20);
      send_frame(a, len, 1'($urandom), kind == 1 ? "R6 random" : "R7 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule